// File: doc/BRIEF.md
# UART Framing Engine with Fractional Baud Timing

This block is the bit-level core of a serial port. It serialises bytes onto a transmit line and deserialises frames from a receive line. It times every bit from the reference clock `clk`, which is 24 MHz in the intended system. The bit period is set by a 16-bit integer divisor and a 3-bit fractional adder, and it equals 16·div + frac + 16 reference cycles. The frame format comes from a packed line-format byte: the data length (5 to 8 bits), whether a parity bit is present and which sense it has, and one or two stop bits.

Configuration is written with a single strobe. A write whose divisor is zero is dropped as a whole, so the format and timing already in force stay in place. Bytes enter through a valid/ready handshake. Each received frame comes out as a one-cycle pulse that carries the data together with parity, framing and break flags. The configuration is assumed to stay unchanged while a frame is in flight.

Top module: `uart_frame_engine`

## Requirements
- R1: The data length is `cfg_lcr[1:0]` + 5 bits. A frame is a start bit of 0, then the data bits least significant bit first, then the optional parity bit, then the stop bits, which are 1.
- R2: `cfg_lcr[2]` = 1 gives two stop bits and `cfg_lcr[2]` = 0 gives one stop bit.
- R3: `cfg_lcr[5]` = 1 inserts a parity bit directly after the data. `cfg_lcr[3]` = 1 makes the parity even (the data ones plus the parity bit form an even count) and `cfg_lcr[3]` = 0 makes it odd.
- R4: Each transmitted bit lasts exactly 16·`cfg_div` + `cfg_frac` + 16 clock cycles, using the values taken by the last accepted `cfg_wr`.
- R5: A `cfg_wr` with `cfg_div` = 0 changes nothing. The format and bit period in force before it remain active.
- R6: `cfg_lcr` bits 4, 6 (infrared select) and 7 have no effect on framing or timing.
- R7: `txd` idles at 1 and `tx_ready` is 1 when idle. A byte is taken on a cycle with `tx_valid` and `tx_ready` both high. The start bit appears on the next cycle, and `tx_ready` returns exactly (frame bits × bit period) cycles after acceptance.
- R8: The receiver samples each bit near its middle. It pulses `rx_valid` for one cycle at the last stop-bit sample, with `rx_data` zero-extended above the data length.
- R9: `rx_parity_err` is set with `rx_valid` when parity is enabled and the received parity bit disagrees with the configured sense.
- R10: `rx_frame_err` is set with `rx_valid` when any stop bit is sampled as 0, including the second of two stop bits.
- R11: When every sample of a frame is 0, `rx_break` and `rx_frame_err` are both set. The receiver then waits for the line to return to 1 before it looks for another start bit, so a long low period yields one report.
- R12: After reset `txd` = 1, `tx_ready` = 1, `rx_valid` = 0, the format is 5 data bits with no parity and one stop bit, and the bit period is 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all timing counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Strobe: take the three configuration fields below |
| cfg_lcr | input | 8 | Line-format byte (length, stop, parity fields) |
| cfg_div | input | DIV_W (16) | Integer bit-period divisor |
| cfg_frac | input | FRAC_W (3) | Fractional cycles added per bit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | One-cycle pulse: a received frame is complete |
| rx_data | output | 8 | Received data, zero-extended |
| rx_parity_err | output | 1 | Parity mismatch in the reported frame |
| rx_frame_err | output | 1 | A stop bit of the reported frame was 0 |
| rx_break | output | 1 | The reported frame was all zeros |

## Verification
The hardest state to reach from the ports is a receive line held low across a full frame and well beyond it. The break must be reported once, and the receiver must then re-arm only after the line rises. The bench turns off loopback and drives `rxd` low for three frame lengths. It checks that exactly one pulse appears with both break and framing flags, and then sends a clean frame to show the receiver has recovered. Stop-bit faults on the second of two stop bits and flipped parity bits are produced the same way. All 32 line formats are swept through a transmit-to-receive loopback, and the waveform is compared cycle by cycle against frames computed in the bench.

// File: rtl/uart_fe_pkg.sv
// Shared types and helpers for the UART framing engine.
// Assumes the line-format byte is decoded identically by transmitter and receiver.
package uart_fe_pkg;

    typedef struct packed {
        logic       par_en;
        logic       par_even;
        logic       two_stop;
        logic [1:0] len_code;
    } line_fmt_t;

    // Number of data bits, 5..8.
    function automatic logic [3:0] data_bits(input line_fmt_t f);
        return 4'({2'b00, f.len_code}) + 4'd5;
    endfunction

    // Total bits on the wire: start + data + parity + stop(s).
    function automatic logic [3:0] frame_bits(input line_fmt_t f);
        return 4'd2 + data_bits(f) + 4'({3'b000, f.par_en}) + 4'({3'b000, f.two_stop});
    endfunction

    // Parity bit for the low data bits selected by the format.
    function automatic logic parity_bit(input logic [7:0] d, input line_fmt_t f);
        logic [7:0] m;
        m = d & (8'hFF >> (2'd3 - f.len_code));
        return f.par_even ? (^m) : ~(^m);
    endfunction

endpackage

// File: rtl/uart_fe_cfg.sv
// Holds the active line format and bit period.
// Assumes cfg_wr is a single-cycle strobe; a zero divisor discards the whole write.
module uart_fe_cfg
    import uart_fe_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3,
    parameter int PER_W  = DIV_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        lcr_in,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [FRAC_W-1:0] frac_in,
    output line_fmt_t         fmt,
    output logic [PER_W-1:0]  period
);

    logic unused_lcr_bits;
    assign unused_lcr_bits = ^{lcr_in[7:6], lcr_in[4]};

    // Capture format and period on a write with a nonzero divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt    <= '0;
            period <= PER_W'(16);
        end else if (cfg_wr && (div_in != '0)) begin
            fmt.par_en   <= lcr_in[5];
            fmt.par_even <= lcr_in[3];
            fmt.two_stop <= lcr_in[2];
            fmt.len_code <= lcr_in[1:0];
            period       <= (PER_W'(div_in) << 4) + PER_W'(frac_in) + PER_W'(16);
        end
    end

    // R5
    zero_div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && div_in == '0) |=> ($stable(period) && $stable(fmt)));

endmodule

// File: rtl/uart_fe_tx.sv
// Transmit serialiser: builds a whole frame on acceptance and shifts it out.
// Assumes format and period are stable while a frame is being sent.
module uart_fe_tx
    import uart_fe_pkg::*;
#(
    parameter int PER_W = 21,
    localparam int FR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_fmt_t        fmt,
    input  logic [PER_W-1:0] period,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             txd
);

    logic             busy;
    logic [FR_W-1:0]  shreg;
    logic [FR_W-1:0]  frame;
    logic [PER_W-1:0] cnt;
    logic [3:0]       idx;
    logic [3:0]       nbits;
    logic [3:0]       dbits;

    // Assemble start, data, parity and idle-high stop bits.
    always_comb begin
        dbits = data_bits(fmt);
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (4'(i) < dbits) frame[i+1] = tx_data[i];
        end
        if (fmt.par_en) frame[dbits + 4'd1] = parity_bit(tx_data, fmt);
    end

    // Accept a byte when idle, then shift one bit per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
            cnt   <= '0;
            idx   <= '0;
            nbits <= '0;
        end else if (!busy) begin
            if (tx_valid) begin
                busy  <= 1'b1;
                shreg <= frame;
                cnt   <= '0;
                idx   <= '0;
                nbits <= frame_bits(fmt);
            end
        end else if (cnt == period - PER_W'(1)) begin
            cnt   <= '0;
            shreg <= {1'b1, shreg[FR_W-1:1]};
            if (idx == nbits - 4'd1) busy <= 1'b0;
            else                     idx  <= idx + 4'd1;
        end else begin
            cnt <= cnt + PER_W'(1);
        end
    end

    assign tx_ready = !busy;
    assign txd      = busy ? shreg[0] : 1'b1;

    // R7
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    // R7
    start_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!txd && !tx_ready));

endmodule

// File: rtl/uart_fe_rx.sv
// Receive deserialiser: synchronises the line, samples mid-bit, reports frames.
// Assumes format and period are stable while a frame is being received.
module uart_fe_rx
    import uart_fe_pkg::*;
#(
    parameter int PER_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_fmt_t        fmt,
    input  logic [PER_W-1:0] period,
    input  logic             rxd_in,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             rx_brk
);

    typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_WAIT_HI} rx_state_t;

    rx_state_t        st;
    logic             sync1, line;
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] target;
    logic [3:0]       idx;
    logic [3:0]       nbits;
    logic [3:0]       dbits;
    logic [7:0]       data;
    logic             par_q;
    logic             frm_bad;
    logic             all_zero;
    logic             is_stop;

    assign dbits   = data_bits(fmt);
    assign target  = (idx == 4'd0) ? (period >> 1) : (period - PER_W'(1));
    assign is_stop = idx > (dbits + 4'({3'b000, fmt.par_en}));

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            line  <= 1'b1;
        end else begin
            sync1 <= rxd_in;
            line  <= sync1;
        end
    end

    // Frame sequencing, mid-bit sampling and result reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= RX_IDLE;
            cnt        <= '0;
            idx        <= '0;
            nbits      <= '0;
            data       <= '0;
            par_q      <= 1'b0;
            frm_bad    <= 1'b0;
            all_zero   <= 1'b1;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
            rx_brk     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (st)
                RX_IDLE: if (!line) begin
                    st       <= RX_BITS;
                    cnt      <= '0;
                    idx      <= '0;
                    data     <= '0;
                    frm_bad  <= 1'b0;
                    all_zero <= 1'b1;
                    nbits    <= frame_bits(fmt);
                end
                RX_BITS: if (cnt != target) begin
                    cnt <= cnt + PER_W'(1);
                end else begin
                    cnt      <= '0;
                    all_zero <= all_zero & ~line;
                    if (idx == 4'd0 && line) begin
                        st <= RX_IDLE;
                    end else begin
                        if (idx != 4'd0 && idx <= dbits) data[3'(idx - 4'd1)] <= line;
                        if (fmt.par_en && idx == dbits + 4'd1) par_q <= line;
                        if (is_stop && !line) frm_bad <= 1'b1;
                        if (idx == nbits - 4'd1) begin
                            rx_valid   <= 1'b1;
                            rx_data    <= data;
                            rx_par_err <= fmt.par_en && (par_q != parity_bit(data, fmt));
                            rx_frm_err <= frm_bad | ~line;
                            rx_brk     <= all_zero & ~line;
                            st         <= line ? RX_IDLE : RX_WAIT_HI;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                end
                RX_WAIT_HI: if (line) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11
    break_is_frame_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_frm_err && rx_data == 8'h00));

endmodule

// File: rtl/uart_frame_engine.sv
// Top of the UART framing engine: configuration, transmitter, receiver.
// Assumes clk is the baud reference clock and configuration changes only when idle.
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_lcr,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic              tx_valid,
    input  logic [7:0]        tx_data,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [7:0]        rx_data,
    output logic              rx_parity_err,
    output logic              rx_frame_err,
    output logic              rx_break
);

    localparam int PER_W = DIV_W + 5;

    line_fmt_t        fmt;
    logic [PER_W-1:0] period;

    uart_fe_cfg #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .PER_W(PER_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .lcr_in(cfg_lcr),
        .div_in(cfg_div), .frac_in(cfg_frac), .fmt(fmt), .period(period)
    );

    uart_fe_tx #(.PER_W(PER_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .period(period),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd)
    );

    uart_fe_rx #(.PER_W(PER_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .period(period), .rxd_in(rxd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_parity_err),
        .rx_frm_err(rx_frame_err), .rx_brk(rx_break)
    );

endmodule

// File: tb/uart_frame_engine_test.sv
module uart_frame_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_lcr = '0;
    logic [15:0] cfg_div = '0;
    logic [2:0]  cfg_frac = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready, txd, rx_valid, rx_parity_err, rx_frame_err, rx_break;
    logic [7:0]  rx_data;
    logic        loop_en = 1'b1;
    logic        rx_drive = 1'b1;
    logic        rxd;

    int checks = 0;
    int fails = 0;
    int rx_cnt = 0;
    logic [7:0] cap_data;
    logic cap_par, cap_frm, cap_brk;

    always #2 clk = ~clk;
    assign rxd = loop_en ? txd : rx_drive;

    uart_frame_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_lcr(cfg_lcr),
        .cfg_div(cfg_div), .cfg_frac(cfg_frac), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break)
    );

    // Capture receive reports away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt++;
            cap_data = rx_data;
            cap_par  = rx_parity_err;
            cap_frm  = rx_frame_err;
            cap_brk  = rx_break;
        end
    end

    function automatic int dlen_of(input logic [7:0] l);
        return int'(l[1:0]) + 5;
    endfunction

    function automatic int nbits_of(input logic [7:0] l);
        return 2 + dlen_of(l) + int'(l[5]) + int'(l[2]);
    endfunction

    function automatic logic [7:0] mask_of(input logic [7:0] l, input logic [7:0] d);
        return d & 8'((1 << dlen_of(l)) - 1);
    endfunction

    // Expected wire bits, computed arithmetically: bit k is sent k-th.
    function automatic logic [11:0] frame_of(input logic [7:0] l, input logic [7:0] d);
        logic [11:0] f;
        int ones;
        f = '1;
        f[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < dlen_of(l); i++) begin
            f[i+1] = d[i];
            ones += int'(d[i]);
        end
        if (l[5]) f[dlen_of(l)+1] = l[3] ? 1'(ones % 2) : 1'(1 - ones % 2);
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic configure(input logic [7:0] l, input logic [15:0] dv, input logic [2:0] fr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_lcr = l; cfg_div = dv; cfg_frac = fr;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Send one byte and compare txd on every cycle of the frame.
    task automatic send_check(input logic [7:0] l, input logic [7:0] d, input int p, input string req);
        logic [11:0] fr;
        int n;
        int bad_c;
        logic bad_v;
        fr = frame_of(l, d);
        n = nbits_of(l);
        bad_c = -1;
        bad_v = 1'b0;
        @(negedge clk);
        tx_valid = 1'b1; tx_data = d;
        @(posedge clk);
        for (int c = 0; c < n * p; c++) begin
            @(negedge clk);
            if (c == 0) tx_valid = 1'b0;
            if (txd !== fr[c / p] && bad_c < 0) begin
                bad_c = c;
                bad_v = txd;
            end
        end
        check(bad_c < 0, req, int'(bad_v), (bad_c < 0) ? 0 : int'(fr[bad_c / p]));
        @(negedge clk);
        check(tx_ready === 1'b1 && txd === 1'b1, "R7 ready after frame", int'({tx_ready, txd}), 3);
    endtask

    task automatic drive_bits(input logic [11:0] f, input int n, input int p);
        for (int k = 0; k < n; k++) begin
            rx_drive = f[k];
            repeat (p) @(negedge clk);
        end
        rx_drive = 1'b1;
        repeat (2 * p) @(negedge clk);
    endtask

    task automatic check_rx(input int cnt0, input logic [7:0] d, input logic par,
                            input logic frm, input logic brk, input string req);
        check(rx_cnt == cnt0 + 1, req, rx_cnt - cnt0, 1);
        check(cap_data === d && cap_par === par && cap_frm === frm && cap_brk === brk, req,
              int'({cap_par, cap_frm, cap_brk, cap_data}), int'({par, frm, brk, d}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int cnt0;
        logic [7:0] l;
        logic [7:0] d;
        logic [11:0] f;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(txd === 1'b1 && tx_ready === 1'b1 && rx_valid === 1'b0, "R12 reset outputs",
              int'({txd, tx_ready, rx_valid}), 6);
        // R12 default format 5N1 with 16-cycle bits
        cnt0 = rx_cnt;
        send_check(8'h00, 8'hF5, 16, "R12 default frame");
        check_rx(cnt0, 8'h15, 1'b0, 1'b0, 1'b0, "R12 R8 default receive");

        // R1 R2 R3 R6 R8: all 32 formats in loopback at 32-cycle bits
        for (int fi = 0; fi < 32; fi++) begin
            l = '0;
            l[1:0] = 2'(fi);
            l[2] = fi[2];
            l[3] = fi[3];
            l[5] = fi[4];
            l[6] = fi[0] ^ fi[3];
            l[4] = fi[1];
            configure(l, 16'd1, 3'd0);
            for (int di = 0; di < 2; di++) begin
                d = (di == 0) ? 8'hA5 : 8'(8'h5A ^ (fi * 29));
                cnt0 = rx_cnt;
                send_check(l, d, 32, "R1/R2/R3/R6 tx frame");
                check_rx(cnt0, mask_of(l, d), 1'b0, 1'b0, 1'b0, "R8/R9 loopback receive");
            end
        end

        // R4: divisor and fraction sweep
        for (int dv = 1; dv <= 3; dv++) begin
            for (int fr = 0; fr < 8; fr++) begin
                configure(8'h03, 16'(dv), 3'(fr));
                send_check(8'h03, 8'h55, 16 * dv + fr + 16, "R4 bit period");
            end
        end

        // R5: zero divisor write leaves 8N1 at 71-cycle bits in force
        configure(8'h2C, 16'd0, 3'd2);
        send_check(8'h03, 8'hC3, 71, "R5 zero divisor ignored");

        // Receive-side faults with the bench driving the line
        configure(8'h2B, 16'd1, 3'd0);
        loop_en = 1'b0;
        repeat (64) @(negedge clk);
        cnt0 = rx_cnt;
        f = frame_of(8'h2B, 8'h3A);
        drive_bits(f, 11, 32);
        check_rx(cnt0, 8'h3A, 1'b0, 1'b0, 1'b0, "R9 clean parity frame");
        cnt0 = rx_cnt;
        f[9] = ~f[9];
        drive_bits(f, 11, 32);
        check_rx(cnt0, 8'h3A, 1'b1, 1'b0, 1'b0, "R9 parity error");
        cnt0 = rx_cnt;
        f = frame_of(8'h2B, 8'h81);
        f[10] = 1'b0;
        drive_bits(f, 11, 32);
        check_rx(cnt0, 8'h81, 1'b0, 1'b1, 1'b0, "R10 stop bit low");

        // R11: long low line gives one break report, then recovery
        cnt0 = rx_cnt;
        rx_drive = 1'b0;
        repeat (33 * 32) @(negedge clk);
        rx_drive = 1'b1;
        repeat (64) @(negedge clk);
        check_rx(cnt0, 8'h00, 1'b0, 1'b1, 1'b1, "R11 break once");
        cnt0 = rx_cnt;
        drive_bits(frame_of(8'h2B, 8'h6E), 11, 32);
        check_rx(cnt0, 8'h6E, 1'b0, 1'b0, 1'b0, "R11 rearm after break");

        // R2 R10: second of two stop bits sampled low
        configure(8'h07, 16'd1, 3'd0);
        repeat (8) @(negedge clk);
        cnt0 = rx_cnt;
        f = frame_of(8'h07, 8'h9C);
        f[10] = 1'b0;
        drive_bits(f, 11, 32);
        check_rx(cnt0, 8'h9C, 1'b0, 1'b1, 1'b0, "R2/R10 second stop low");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule